// File: doc/BRIEF.md
# Output impedance calibration controller

This block keeps a 5-bit output driver impedance code in line with an external comparator. The comparator reports whether the driver is too strong or too weak. At a fixed interval of 64 clock cycles the controller reads that decision and moves an internal target code one step up, one step down, or leaves it where it is. The target never wraps: it stops at the lowest and highest codes.

The driver must not change strength while it is driving the pins. For that reason the target is copied to the applied code only while the output is in high impedance. The output goes to high impedance in a write cycle, in a deselect cycle, or when the asynchronous output disable is held around a clock edge. All three are sampled into one registered high-impedance state. If several evaluations pass while the output is driving, the next high-impedance window loads the latest target in one go.

After reset the controller counts 4096 cycles. A calibrated flag then rises at the first output transition from low impedance to high impedance, and it stays set until the next reset.

Top module: `zq_cal_ctrl`

## Requirements
- R1: In the cycle after a synchronous reset, `drv_code` is 16 and `cal_done` is 0.
- R2: An evaluation happens on every 64th clock edge after reset, and only then. While the output stays in high impedance and the comparator keeps asking for a change, `drv_code` therefore changes exactly 10 times in any 640 consecutive cycles.
- R3: At an evaluation the target follows the comparator inputs. `cmp_up`=1 with `cmp_dn`=0 adds one. `cmp_dn`=1 with `cmp_up`=0 subtracts one. Both high or both low leave the target unchanged.
- R4: The target saturates at 31 and at 0 and never wraps from one end to the other.
- R5: `drv_code` changes only on an edge where the registered high-impedance state (the OR of the three sources, captured at the previous edge) is 1.
- R6: Each of `wr_cyc`, `desel_cyc` and `oe_dis` opens a high-impedance window on its own.
- R7: When a window opens after several evaluations, `drv_code` takes the latest target directly, even when that target is more than one step away.
- R8: `cal_done` rises only on an edge where at least 4096 edges have passed since reset and the high-impedance state goes from 0 to 1. A window that is already open when the count completes does not set the flag. Once set, the flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_up | input | 1 | Comparator asks for a higher code |
| cmp_dn | input | 1 | Comparator asks for a lower code |
| wr_cyc | input | 1 | Write cycle (output in high impedance) |
| desel_cyc | input | 1 | Deselect cycle (output in high impedance) |
| oe_dis | input | 1 | Asynchronous output disable, held stable around the edge |
| drv_code | output | 5 | Impedance code applied to the driver |
| cal_done | output | 1 | Calibration complete flag |

## Verification
The hardest case to reach is the calibrated flag's condition. The warm-up count must have completed, and only a fresh low-to-high-impedance transition may set the flag. The stimulus keeps the output in high impedance without a break across the 4096-cycle point. It then holds that state for a while and shows that the flag stays low. Only after that does it drop to low impedance and reopen a window. Early windows before the count completes show that transitions that come too soon are ignored. A long low-impedance stretch spanning two evaluations shows the multi-step catch-up when one write cycle follows.

// File: rtl/zq_cal_pkg.sv
package zq_cal_pkg;

    localparam int unsigned CODE_W = 5;

    typedef logic [CODE_W-1:0] zq_code_t;

    localparam zq_code_t CODE_MID = zq_code_t'(1 << (CODE_W - 1));
    localparam zq_code_t CODE_MAX = '1;
    localparam zq_code_t CODE_MIN = '0;

    typedef enum logic [1:0] {
        DIR_HOLD = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DN   = 2'd2
    } zq_dir_e;

    typedef struct packed {
        logic wr;
        logic desel;
        logic oe_dis;
    } hiz_src_t;

    function automatic zq_dir_e decode_dir(input logic up, input logic dn);
        if (up && !dn) return DIR_UP;
        if (dn && !up) return DIR_DN;
        return DIR_HOLD;
    endfunction

    function automatic zq_code_t step_code(input zq_code_t code, input zq_dir_e dir);
        case (dir)
            DIR_UP:  return (code == CODE_MAX) ? code : code + 1'b1;
            DIR_DN:  return (code == CODE_MIN) ? code : code - 1'b1;
            default: return code;
        endcase
    endfunction

endpackage

// File: rtl/zq_eval_timer.sv
module zq_eval_timer #(
    parameter int unsigned PERIOD = 64
) (
    input  logic clk,
    input  logic rst,
    output logic eval_o
);
    localparam int unsigned CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;

    assign eval_o = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= '0;
        else if (eval_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/zq_target.sv
module zq_target
    import zq_cal_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     eval_i,
    input  zq_dir_e  dir_i,
    output zq_code_t tgt_o
);
    always_ff @(posedge clk) begin
        if (rst)         tgt_o <= CODE_MID;
        else if (eval_i) tgt_o <= step_code(tgt_o, dir_i);
    end
endmodule

// File: rtl/zq_apply.sv
module zq_apply
    import zq_cal_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  hiz_src_t src_i,
    input  zq_code_t tgt_i,
    output logic     hiz_o,
    output logic     hiz_rise_o,
    output zq_code_t app_o
);
    logic hiz_next;

    assign hiz_next   = src_i.wr | src_i.desel | src_i.oe_dis;
    assign hiz_rise_o = hiz_next & ~hiz_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            hiz_o <= 1'b0;
            app_o <= CODE_MID;
        end else begin
            hiz_o <= hiz_next;
            if (hiz_o) app_o <= tgt_i;
        end
    end
endmodule

// File: rtl/zq_warmup.sv
module zq_warmup #(
    parameter int unsigned CYCLES = 4096
) (
    input  logic clk,
    input  logic rst,
    input  logic hiz_rise_i,
    output logic warm_o,
    output logic cal_o
);
    localparam int unsigned CNT_W = $clog2(CYCLES + 1);
    localparam logic [CNT_W-1:0] DONE = CNT_W'(CYCLES);

    logic [CNT_W-1:0] cnt_q;

    assign warm_o = (cnt_q == DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            cal_o <= 1'b0;
        end else begin
            if (!warm_o) cnt_q <= cnt_q + 1'b1;
            if (warm_o && hiz_rise_i) cal_o <= 1'b1;
        end
    end
endmodule

// File: rtl/zq_cal_ctrl.sv
module zq_cal_ctrl
    import zq_cal_pkg::*;
#(
    parameter int unsigned EVAL_PERIOD   = 64,
    parameter int unsigned WARMUP_CYCLES = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmp_up,
    input  logic              cmp_dn,
    input  logic              wr_cyc,
    input  logic              desel_cyc,
    input  logic              oe_dis,
    output logic [CODE_W-1:0] drv_code,
    output logic              cal_done
);
    logic     eval_pulse;
    logic     hiz_q;
    logic     hiz_rise;
    logic     warm;
    zq_code_t tgt_code;
    zq_code_t app_code;
    hiz_src_t src;

    assign src = '{wr: wr_cyc, desel: desel_cyc, oe_dis: oe_dis};

    zq_eval_timer #(.PERIOD(EVAL_PERIOD)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .eval_o (eval_pulse)
    );

    zq_target u_target (
        .clk    (clk),
        .rst    (rst),
        .eval_i (eval_pulse),
        .dir_i  (decode_dir(cmp_up, cmp_dn)),
        .tgt_o  (tgt_code)
    );

    zq_apply u_apply (
        .clk        (clk),
        .rst        (rst),
        .src_i      (src),
        .tgt_i      (tgt_code),
        .hiz_o      (hiz_q),
        .hiz_rise_o (hiz_rise),
        .app_o      (app_code)
    );

    zq_warmup #(.CYCLES(WARMUP_CYCLES)) u_warm (
        .clk        (clk),
        .rst        (rst),
        .hiz_rise_i (hiz_rise),
        .warm_o     (warm),
        .cal_o      (cal_done)
    );

    assign drv_code = app_code;
endmodule

// File: rtl/zq_cal_ctrl_chk.sv
module zq_cal_ctrl_chk
    import zq_cal_pkg::*;
(
    input logic     clk,
    input logic     rst,
    input zq_code_t tgt,
    input zq_code_t app,
    input logic     hiz_q,
    input logic     eval,
    input logic     warm,
    input logic     cal
);
    // R2: the target moves only on an evaluation edge
    a_r2_eval_only: assert property (@(posedge clk) disable iff (rst)
        !$stable(tgt) |-> $past(eval));

    // R3: the target moves by exactly one step
    a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
        !$stable(tgt) |-> ({1'b0, tgt} == {1'b0, $past(tgt)} + 6'd1) ||
                          ({1'b0, tgt} + 6'd1 == {1'b0, $past(tgt)}));

    // R4: no wrap at either end
    a_r4_no_wrap: assert property (@(posedge clk) disable iff (rst)
        !$stable(tgt) |-> !((tgt == CODE_MIN) && ($past(tgt) == CODE_MAX)) &&
                          !((tgt == CODE_MAX) && ($past(tgt) == CODE_MIN)));

    // R5: the applied code changes only in a high-impedance window
    a_r5_apply_in_hiz: assert property (@(posedge clk) disable iff (rst)
        !$stable(app) |-> $past(hiz_q));

    // R8: the flag rises only after warm-up on a fresh window
    a_r8_cal_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(cal) |-> $past(warm) && hiz_q && !$past(hiz_q));

    // R8: the flag is sticky
    a_r8_cal_sticky: assert property (@(posedge clk) disable iff (rst)
        cal |=> cal);
endmodule

bind zq_cal_ctrl zq_cal_ctrl_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .tgt   (tgt_code),
    .app   (drv_code),
    .hiz_q (hiz_q),
    .eval  (eval_pulse),
    .warm  (warm),
    .cal   (cal_done)
);

// File: tb/zq_cal_ctrl_test.sv
`timescale 1ns/1ps
module zq_cal_ctrl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmp_up = 1'b0, cmp_dn = 1'b0;
    logic       wr_cyc = 1'b0, desel_cyc = 1'b0, oe_dis = 1'b0;
    logic [4:0] drv_code;
    logic       cal_done;

    int checks = 0;
    int fails  = 0;

    // reference model state
    int m_cyc, m_tgt, m_app;
    bit m_hiz, m_cal;

    always #5 clk = ~clk;

    zq_cal_ctrl uut (
        .clk(clk), .rst(rst), .cmp_up(cmp_up), .cmp_dn(cmp_dn),
        .wr_cyc(wr_cyc), .desel_cyc(desel_cyc), .oe_dis(oe_dis),
        .drv_code(drv_code), .cal_done(cal_done)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input bit r, input bit u, input bit d,
                        input bit w, input bit s, input bit o, input string tag);
        int  n_tgt, n_app;
        bit  n_hiz, n_cal;
        rst = r; cmp_up = u; cmp_dn = d; wr_cyc = w; desel_cyc = s; oe_dis = o;
        @(posedge clk);
        @(negedge clk);
        if (r) begin
            m_cyc = 0; m_tgt = 16; m_app = 16; m_hiz = 0; m_cal = 0;
        end else begin
            n_tgt = m_tgt;
            if ((m_cyc % 64) == 63) begin
                if (u && !d && m_tgt < 31) n_tgt = m_tgt + 1;
                if (d && !u && m_tgt > 0)  n_tgt = m_tgt - 1;
            end
            n_app = m_hiz ? m_tgt : m_app;
            n_hiz = w | s | o;
            n_cal = m_cal | ((m_cyc >= 4096) && n_hiz && !m_hiz);
            m_tgt = n_tgt; m_app = n_app; m_hiz = n_hiz; m_cal = n_cal;
            m_cyc++;
        end
        check(tag, drv_code, m_app);
        check("R8", cal_done, m_cal);
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int prev;
        int changes;
        // R1 reset state
        for (int i = 0; i < 3; i++) tick(1, 0, 0, 0, 0, 0, "R1");
        check("R1", drv_code, 16);
        check("R1", cal_done, 0);

        // R5: evaluations while driving do not reach the driver
        for (int i = 0; i < 130; i++) tick(0, 1, 0, 0, 0, 0, "R5");
        check("R5", drv_code, 16);

        // R7: a single write window loads the target two steps away
        tick(0, 0, 0, 1, 0, 0, "R7");
        tick(0, 0, 0, 0, 0, 0, "R7");
        check("R7", drv_code, 18);

        // R6: each high-impedance source alone opens a window
        for (int i = 0; i < 64;  i++) tick(0, 1, 0, 0, 1, 0, "R6");
        for (int i = 0; i < 128; i++) tick(0, 0, 1, 0, 0, 1, "R6");
        for (int i = 0; i < 64;  i++) tick(0, 1, 0, 1, 0, 0, "R6");

        // R2: exactly ten changes in 640 cycles
        changes = 0;
        for (int i = 0; i < 640; i++) begin
            prev = drv_code;
            tick(0, 1, 0, 1, 0, 0, "R2");
            if (drv_code != prev) changes++;
        end
        check("R2", changes, 10);

        // R4: saturate high, then low
        for (int i = 0; i < 20 * 64; i++) tick(0, 1, 0, i[6], ~i[6], 0, "R4");
        check("R4", drv_code, 31);
        for (int i = 0; i < 35 * 64; i++) tick(0, 0, 1, 0, 1, i[7], "R4");
        check("R4", drv_code, 0);

        // R3: both or neither request holds the code
        for (int i = 0; i < 64; i++) tick(0, 1, 1, 1, 0, 0, "R3");
        for (int i = 0; i < 64; i++) tick(0, 0, 0, 1, 0, 0, "R3");
        check("R3", drv_code, 0);
        for (int i = 0; i < 128; i++) tick(0, 1, 0, 1, 0, 0, "R3");
        check("R3", drv_code, 2);

        // R8: window already open across warm-up end does not calibrate
        for (int i = 0; i < 200; i++) tick(0, 0, 0, 0, 1, 0, "R8");
        check("R8", cal_done, 0);
        for (int i = 0; i < 5; i++) tick(0, 0, 0, 0, 0, 0, "R8");
        check("R8", cal_done, 0);
        tick(0, 0, 0, 0, 0, 1, "R8");
        check("R8", cal_done, 1);
        for (int i = 0; i < 10; i++) tick(0, 0, 0, 0, 0, 0, "R8");
        check("R8", cal_done, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule